// File: doc/BRIEF.md
# Floating-Point NaN Special-Operand Precheck

This block sits ahead of a floating-point datapath and settles, one operation at a time, what happens when an operand is a NaN. For each strobed request it looks at one or two operands of single or double precision. It also takes the operation class and the control bits held in its own status word. One cycle later it returns a verdict: proceed normally, write the canonical quiet NaN, or hand the operation to software. Alongside the verdict it gives a 64-bit result word and the updated sticky invalid-operation flag.

Three regimes govern arithmetic operations. In the fast regime, flush-to-zero and default-NaN are both on and every exception trap enable is off; any NaN yields the canonical NaN and a trap is never issued. With default-NaN on outside the fast regime, only a signaling NaN with its trap enabled reaches software. With default-NaN off (full compliance), every NaN operand is sent to software. Transfers and sign-only moves never inspect NaNs and never alter their payload.

Top module: `nan_precheck`

## Requirements
- R1: An operand is a NaN exactly when its exponent field is all ones and its fraction field is nonzero (8/23 bits in single, 11/52 bits in double). A NaN is signaling when the fraction MSB is 0 and quiet when it is 1. An infinity is not a NaN.
- R2: In single precision (`is_double`=0) only bits 31:0 of each operand are used. The upper 32 bits of `res_data` are then zero.
- R3: `out_valid`, `verdict` and `res_data` are registered: they reflect a request strobed by `in_valid` one clock later, and `out_valid` is low in a cycle that follows no request.
- R4: `fast_mode` is 1 exactly when status bit 24 (flush-to-zero) and bit 25 (default-NaN) are set and all trap enables, status bits 12:8, are clear.
- R5: Verdict codes are 0 proceed, 1 default NaN, 2 trap. Op class codes are 0 arithmetic, 1 transfer, 2 copy, 3 absolute, 4 negate; codes 5 to 7 act as transfer. With default-NaN clear, an arithmetic request with any NaN operand gives verdict 2.
- R6: In fast mode, an arithmetic request with any NaN operand gives verdict 1, never 2.
- R7: With default-NaN set outside fast mode, an arithmetic request gives verdict 2 when a signaling NaN is present and status bit 8 (invalid trap enable) is set. It gives verdict 1 for any other NaN combination.
- R8: With verdict 1, `res_data` is 0x7FC00000 in single precision and 0x7FF8000000000000 in double precision.
- R9: An arithmetic request with a signaling NaN operand sets status bit 0. A quiet NaN alone, or any non-arithmetic request, leaves it unchanged.
- R10: Transfer, copy and codes 5 to 7 give verdict 0 with `res_data` equal to operand A bit for bit, NaN payload included.
- R11: Absolute value clears the sign bit (bit 31 single, bit 63 double) and negate inverts it. All other bits pass unchanged and the verdict is 0.
- R12: Status bit 0 is sticky and falls only through `stat_wr`. Only bits 0, 12:8, 24 and 25 are writable and all other bits read 0. A signaling-NaN event in the same cycle as a write still leaves bit 0 set.
- R13: An arithmetic request with no NaN operand gives verdict 0, and `res_data` equals operand A. Verdicts 1 and 2 for a trap also return operand A unchanged except that verdict 1 returns the canonical NaN.
- R14: Operand B is examined only when `two_op` is 1. With `two_op` 0, a NaN in B changes neither the verdict nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_class | input | 3 | Operation class code |
| is_double | input | 1 | 1 for double precision, 0 for single |
| two_op | input | 1 | Operand B takes part |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | 32 | Status word write value |
| out_valid | output | 1 | Verdict valid |
| verdict | output | 2 | Verdict code |
| res_data | output | 64 | Result word |
| stat_rd | output | 32 | Current status word |
| fast_mode | output | 1 | Fast regime active |

## Verification
The sweep crosses every control combination with every class and precision, and with each pair from a set of zeros, ones, signed infinities and quiet and signaling NaNs carrying payloads. A design that took an infinity for a NaN, or mixed up the quiet/signaling bit, would trap or raise the flag on the wrong pairs. If B were examined without `two_op`, single-operand requests would trap on a NaN in B. Canonicalizing a pass-through NaN would lose the payload on transfers, and a non-sticky flag or a write that overrides a same-cycle event would show as a missing flag bit after the directed collision case.

// File: rtl/nanchk_pkg.sv
package nanchk_pkg;

    localparam int SP_EXP  = 8;
    localparam int SP_FRAC = 23;
    localparam int DP_EXP  = 11;
    localparam int DP_FRAC = 52;
    localparam int WORD_W  = 1 + DP_EXP + DP_FRAC;
    localparam int SP_W    = 1 + SP_EXP + SP_FRAC;

    typedef enum logic [2:0] {
        OP_ARITH = 3'd0,
        OP_XFER  = 3'd1,
        OP_COPY  = 3'd2,
        OP_ABS   = 3'd3,
        OP_NEG   = 3'd4
    } op_cls_e;

    typedef enum logic [1:0] {
        V_PROCEED = 2'd0,
        V_DEFNAN  = 2'd1,
        V_TRAP    = 2'd2
    } verdict_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_qnan;
        logic is_inf;
    } opnd_cls_t;

    typedef struct packed {
        logic ftz;
        logic dnan;
        logic inv_te;
        logic any_te;
        logic fast;
    } ctl_t;

    function automatic logic [WORD_W-1:0] canon_nan(input logic dbl);
        logic [WORD_W-1:0] r;
        r = '0;
        if (dbl) begin
            r[WORD_W-2 -: DP_EXP] = '1;
            r[DP_FRAC-1]          = 1'b1;
        end else begin
            r[SP_W-2 -: SP_EXP]   = '1;
            r[SP_FRAC-1]          = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] narrow(input logic [WORD_W-1:0] v,
                                                 input logic dbl);
        return dbl ? v : {{(WORD_W-SP_W){1'b0}}, v[SP_W-1:0]};
    endfunction

    function automatic logic [WORD_W-1:0] sign_move(input logic [WORD_W-1:0] v,
                                                    input logic dbl,
                                                    input op_cls_e op);
        logic [WORD_W-1:0] r;
        r = narrow(v, dbl);
        if (dbl) begin
            if (op == OP_ABS)      r[WORD_W-1] = 1'b0;
            else if (op == OP_NEG) r[WORD_W-1] = ~r[WORD_W-1];
        end else begin
            if (op == OP_ABS)      r[SP_W-1] = 1'b0;
            else if (op == OP_NEG) r[SP_W-1] = ~r[SP_W-1];
        end
        return r;
    endfunction

endpackage

// File: rtl/nanchk_classify.sv
module nanchk_classify
    import nanchk_pkg::*;
(
    input  logic [WORD_W-1:0] val,
    input  logic              dbl,
    output opnd_cls_t         cls
);
    logic [SP_EXP-1:0]  s_exp;
    logic [SP_FRAC-1:0] s_frac;
    logic [DP_EXP-1:0]  d_exp;
    logic [DP_FRAC-1:0] d_frac;
    logic exp_ones, frac_nz, frac_msb;

    assign s_exp  = val[SP_W-2 -: SP_EXP];
    assign s_frac = val[SP_FRAC-1:0];
    assign d_exp  = val[WORD_W-2 -: DP_EXP];
    assign d_frac = val[DP_FRAC-1:0];

    always_comb begin
        if (dbl) begin
            exp_ones = &d_exp;
            frac_nz  = |d_frac;
            frac_msb = d_frac[DP_FRAC-1];
        end else begin
            exp_ones = &s_exp;
            frac_nz  = |s_frac;
            frac_msb = s_frac[SP_FRAC-1];
        end
        cls.is_nan  = exp_ones & frac_nz;
        cls.is_snan = exp_ones & frac_nz & ~frac_msb;
        cls.is_qnan = exp_ones & frac_msb;
        cls.is_inf  = exp_ones & ~frac_nz;
    end
endmodule

// File: rtl/nanchk_status.sv
module nanchk_status
    import nanchk_pkg::*;
#(
    parameter int STAT_W   = 32,
    parameter int FLAG_BIT = 0,
    parameter int TE_LO    = 8,
    parameter int N_TE     = 5,
    parameter int FTZ_BIT  = 24,
    parameter int DN_BIT   = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic              set_flag,
    output logic [STAT_W-1:0] q,
    output ctl_t              ctl
);
    localparam logic [STAT_W-1:0] ONE  = STAT_W'(1);
    localparam logic [STAT_W-1:0] MASK = (ONE << FLAG_BIT)
                                       | (((ONE << N_TE) - ONE) << TE_LO)
                                       | (ONE << FTZ_BIT)
                                       | (ONE << DN_BIT);

    logic [STAT_W-1:0] nxt;

    always_comb begin
        nxt = wr ? (wdata & MASK) : q;
        if (set_flag) nxt[FLAG_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    always_comb begin
        ctl.ftz    = q[FTZ_BIT];
        ctl.dnan   = q[DN_BIT];
        ctl.inv_te = q[TE_LO];
        ctl.any_te = |q[TE_LO +: N_TE];
        ctl.fast   = q[FTZ_BIT] & q[DN_BIT] & ~(|q[TE_LO +: N_TE]);
    end
endmodule

// File: rtl/nanchk_decide.sv
module nanchk_decide
    import nanchk_pkg::*;
(
    input  op_cls_e           op,
    input  logic              dbl,
    input  logic              two_op,
    input  logic [WORD_W-1:0] opa,
    input  opnd_cls_t         cls_a,
    input  opnd_cls_t         cls_b,
    input  ctl_t              ctl,
    output verdict_e          verdict,
    output logic [WORD_W-1:0] res,
    output logic              raise_inv
);
    logic any_nan, any_snan, arith;

    assign arith    = (op == OP_ARITH);
    assign any_nan  = cls_a.is_nan  | (two_op & cls_b.is_nan);
    assign any_snan = cls_a.is_snan | (two_op & cls_b.is_snan);

    always_comb begin
        verdict   = V_PROCEED;
        res       = narrow(opa, dbl);
        raise_inv = arith & any_snan;
        if (!arith) begin
            res = sign_move(opa, dbl, op);
        end else if (any_nan) begin
            if (ctl.fast) begin
                verdict = V_DEFNAN;
                res     = canon_nan(dbl);
            end else if (!ctl.dnan) begin
                verdict = V_TRAP;
            end else if (any_snan && ctl.inv_te) begin
                verdict = V_TRAP;
            end else begin
                verdict = V_DEFNAN;
                res     = canon_nan(dbl);
            end
        end
    end
endmodule

// File: rtl/nan_precheck.sv
module nan_precheck
    import nanchk_pkg::*;
#(
    parameter int STAT_W   = 32,
    parameter int FLAG_BIT = 0,
    parameter int TE_LO    = 8,
    parameter int N_TE     = 5,
    parameter int FTZ_BIT  = 24,
    parameter int DN_BIT   = 25,
    parameter int N_OPND   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op_class,
    input  logic              is_double,
    input  logic              two_op,
    input  logic [63:0]       opa,
    input  logic [63:0]       opb,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic              out_valid,
    output logic [1:0]        verdict,
    output logic [63:0]       res_data,
    output logic [STAT_W-1:0] stat_rd,
    output logic              fast_mode
);
    logic [WORD_W-1:0] opnd [N_OPND];
    opnd_cls_t         cls  [N_OPND];
    ctl_t              ctl;
    op_cls_e           op_e;
    verdict_e          v_d;
    logic [WORD_W-1:0] res_d;
    logic              raise_d;

    assign opnd[0] = opa;
    assign opnd[1] = opb;

    always_comb begin
        if (op_class <= 3'd4) op_e = op_cls_e'(op_class);
        else                  op_e = OP_XFER;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_cls
        nanchk_classify u_cls (
            .val (opnd[g]),
            .dbl (is_double),
            .cls (cls[g])
        );
    end

    nanchk_status #(
        .STAT_W(STAT_W), .FLAG_BIT(FLAG_BIT), .TE_LO(TE_LO),
        .N_TE(N_TE), .FTZ_BIT(FTZ_BIT), .DN_BIT(DN_BIT)
    ) u_stat (
        .clk      (clk),
        .rst      (rst),
        .wr       (stat_wr),
        .wdata    (stat_wdata),
        .set_flag (in_valid & raise_d),
        .q        (stat_rd),
        .ctl      (ctl)
    );

    nanchk_decide u_dec (
        .op        (op_e),
        .dbl       (is_double),
        .two_op    (two_op),
        .opa       (opa),
        .cls_a     (cls[0]),
        .cls_b     (cls[1]),
        .ctl       (ctl),
        .verdict   (v_d),
        .res       (res_d),
        .raise_inv (raise_d)
    );

    assign fast_mode = ctl.fast;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            verdict   <= V_PROCEED;
            res_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                verdict  <= v_d;
                res_data <= res_d;
            end
        end
    end
endmodule

// File: rtl/nanchk_checker.sv
module nanchk_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [2:0]  op_class,
    input logic        stat_wr,
    input logic        out_valid,
    input logic [1:0]  verdict,
    input logic [63:0] res_data,
    input logic [31:0] stat_rd,
    input logic        fast_mode
);
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r6_fast_never_traps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fast_mode) |=> (verdict != 2'd2));

    a_r10_nonarith_proceeds: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_class != 3'd0) |=> (verdict == 2'd0));

    a_r8_canon_pattern: assert property (@(posedge clk) disable iff (rst)
        (out_valid && verdict == 2'd1) |->
            (res_data == 64'h7FF8_0000_0000_0000 || res_data == 64'h0000_0000_7FC0_0000));

    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_rd[0] && !stat_wr) |=> stat_rd[0]);

    a_r9_nonarith_no_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_class != 3'd0 && !stat_rd[0] && !stat_wr) |=> !stat_rd[0]);

    a_r5_verdict_legal: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (verdict != 2'd3));
endmodule

bind nan_precheck nanchk_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_class  (op_class),
    .stat_wr   (stat_wr),
    .out_valid (out_valid),
    .verdict   (verdict),
    .res_data  (res_data),
    .stat_rd   (stat_rd),
    .fast_mode (fast_mode)
);

// File: tb/tb_nan_precheck.sv
module tb_nan_precheck;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op_class = '0;
    logic        is_double = 1'b0;
    logic        two_op = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        stat_wr = 1'b0;
    logic [31:0] stat_wdata = '0;
    logic        out_valid;
    logic [1:0]  verdict;
    logic [63:0] res_data;
    logic [31:0] stat_rd;
    logic        fast_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nan_precheck dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_class(op_class),
        .is_double(is_double), .two_op(two_op), .opa(opa), .opb(opb),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .out_valid(out_valid),
        .verdict(verdict), .res_data(res_data), .stat_rd(stat_rd),
        .fast_mode(fast_mode)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input bit dbl, input int idx);
        logic [63:0] s [8];
        logic [63:0] d [8];
        s[0] = 64'h0;          d[0] = 64'h0;
        s[1] = 64'h3F80_0000;  d[1] = 64'h3FF0_0000_0000_0000;
        s[2] = 64'h7F80_0000;  d[2] = 64'h7FF0_0000_0000_0000;
        s[3] = 64'hFF80_0000;  d[3] = 64'hFFF0_0000_0000_0000;
        s[4] = 64'h7FC0_0000;  d[4] = 64'h7FF8_0000_0000_0000;
        s[5] = 64'hFFC0_ABCD;  d[5] = 64'hFFF8_0000_0000_ABCD;
        s[6] = 64'h7F80_0001;  d[6] = 64'h7FF0_0000_0000_0001;
        s[7] = 64'hFFA0_0000;  d[7] = 64'hFFF4_0000_0000_0000;
        return dbl ? d[idx] : (s[idx] | 64'hA5A5_5A5A_0000_0000);
    endfunction

    function automatic bit m_nan(input logic [63:0] v, input bit dbl);
        return dbl ? (v[62:52] == 11'h7FF && v[51:0] != 0)
                   : (v[30:23] == 8'hFF && v[22:0] != 0);
    endfunction

    function automatic bit m_snan(input logic [63:0] v, input bit dbl);
        return m_nan(v, dbl) && (dbl ? !v[51] : !v[22]);
    endfunction

    task automatic do_op(input logic [2:0] op, input bit dbl, input bit two,
                         input logic [63:0] a, input logic [63:0] b,
                         input bit wr, input logic [31:0] wd);
        @(negedge clk);
        in_valid = 1'b1; op_class = op; is_double = dbl; two_op = two;
        opa = a; opb = b; stat_wr = wr; stat_wdata = wd;
        @(negedge clk);
        in_valid = 1'b0; stat_wr = 1'b0;
    endtask

    task automatic do_wr(input logic [31:0] wd);
        @(negedge clk);
        stat_wr = 1'b1; stat_wdata = wd;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] a, b, xr, lo;
        logic [1:0]  xv;
        logic [31:0] cw;
        bit ftz, dn, ioe, ofe, fast, nan, snan, flag, ev;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 R12 reset state
        chk(out_valid == 0, "R3 reset out_valid", 64'(out_valid), 64'd0);
        chk(stat_rd == 0, "R12 reset status", 64'(stat_rd), 64'd0);
        chk(fast_mode == 0, "R4 reset fast_mode", 64'(fast_mode), 64'd0);

        // R12 write mask
        do_wr(32'hFFFF_FFFF);
        chk(stat_rd == 32'h0300_1F01, "R12 write mask", 64'(stat_rd), 64'h0300_1F01);
        do_wr(32'h0);
        chk(stat_rd == 0, "R12 explicit clear", 64'(stat_rd), 64'd0);

        for (int cfg = 0; cfg < 16; cfg++) begin
            ftz = cfg[0]; dn = cfg[1]; ioe = cfg[2]; ofe = cfg[3];
            cw = (32'(ftz) << 24) | (32'(dn) << 25) | (32'(ioe) << 8) | (32'(ofe) << 10);
            fast = ftz && dn && !ioe && !ofe;
            do_wr(cw);
            chk(stat_rd == cw, "R12 status readback", 64'(stat_rd), 64'(cw));
            chk(fast_mode == fast, "R4 fast_mode", 64'(fast_mode), 64'(fast));
            flag = 0;
            for (int dbl = 0; dbl < 2; dbl++)
            for (int op = 0; op < 6; op++)
            for (int two = 0; two < 2; two++)
            for (int ia = 0; ia < 8; ia++)
            for (int ib = 0; ib < 8; ib++) begin
                a = pat(dbl[0], ia);
                b = pat(dbl[0], ib);
                lo = dbl ? a : {32'h0, a[31:0]};
                nan  = m_nan(a, dbl[0])  || (two == 1 && m_nan(b, dbl[0]));
                snan = m_snan(a, dbl[0]) || (two == 1 && m_snan(b, dbl[0]));
                xv = 2'd0; xr = lo; ev = 0;
                if (op == 0) begin
                    ev = snan;
                    if (nan) begin
                        if (fast || (dn && !(snan && ioe))) begin
                            xv = 2'd1;
                            xr = dbl ? 64'h7FF8_0000_0000_0000 : 64'h7FC0_0000;
                        end else begin
                            xv = 2'd2;
                        end
                    end
                end else if (op == 3) begin
                    if (dbl) xr[63] = 1'b0; else xr[31] = 1'b0;
                end else if (op == 4) begin
                    if (dbl) xr[63] = ~xr[63]; else xr[31] = ~xr[31];
                end
                do_op(3'(op), dbl[0], two[0], a, b, 1'b0, 32'h0);
                chk(out_valid == 1, "R3 out_valid after strobe", 64'(out_valid), 64'd1);
                if (op == 0 && nan && !dn)
                    chk(verdict == xv, "R5 compliance trap", 64'(verdict), 64'(xv));
                else if (op == 0 && nan && fast)
                    chk(verdict == xv, "R6 fast default NaN", 64'(verdict), 64'(xv));
                else if (op == 0 && nan)
                    chk(verdict == xv, "R7 default-NaN regime", 64'(verdict), 64'(xv));
                else if (op == 0 && two == 0 && m_nan(b, dbl[0]))
                    chk(verdict == xv, "R14 B ignored", 64'(verdict), 64'(xv));
                else
                    chk(verdict == xv, "R1 R13 verdict", 64'(verdict), 64'(xv));
                if (xv == 2'd1)
                    chk(res_data == xr, "R8 canonical NaN", res_data, xr);
                else if (op == 3 || op == 4)
                    chk(res_data == xr, "R11 sign move", res_data, xr);
                else if (op != 0)
                    chk(res_data == xr, "R10 R2 pass-through", res_data, xr);
                else
                    chk(res_data == xr, "R13 operand A", res_data, xr);
                flag = flag | ev;
                chk(stat_rd[0] == flag, "R9 invalid flag", 64'(stat_rd[0]), 64'(flag));
                if (flag) begin
                    do_wr(cw);
                    flag = 0;
                    chk(stat_rd[0] == 0, "R12 flag cleared by write", 64'(stat_rd[0]), 64'd0);
                end
            end
        end

        // R3 idle cycle
        @(negedge clk);
        chk(out_valid == 0, "R3 idle", 64'(out_valid), 64'd0);

        // R12 collision: write of zero with signaling NaN event
        do_wr(32'h0200_0000);
        do_op(3'd0, 1'b0, 1'b0, 64'h7F80_0001, 64'h0, 1'b1, 32'h0);
        chk(stat_rd[0] == 1, "R12 event wins over write", 64'(stat_rd[0]), 64'd1);
        chk(verdict == 2'd1, "R7 verdict uses prior status", 64'(verdict), 64'd1);
        repeat (3) @(negedge clk);
        chk(stat_rd[0] == 1, "R12 flag holds", 64'(stat_rd[0]), 64'd1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule